// File: doc/BRIEF.md
# Output Port Priority Arbiter

This block sits in front of one output port of a non-blocking crossbar switch and decides which of the input ports competing for that output is connected to it. Every requester presents a priority level. That level is looked up by the routing logic from the table entry of the packet's logical address, because packets themselves carry no priority. A packet that is addressed directly by port number has no table entry. Its level is treated as the lowest one, whatever the level field holds.

The arbiter chooses the highest effective level among the eligible requesters. Ties at that level are broken by a rotating pointer. The winner then owns the output until the end of its packet. That end is a normal end marker or an error-end marker, signalled by a strobe from the granted input. If the owner's link fails in the middle of a packet, the arbiter raises a one-cycle request to force an error end onto the output and releases the grant after it. The default size serves eleven requesters: eight link ports, two external ports and a configuration port.

Top module: `out_port_arbiter`

## Requirements
- R1: After reset, `grantVec` is all zero, `forceErrEnd` is low and the round-robin pointer is at requester 0.
- R2: Among eligible requesters, the one with the largest effective level wins. Requester i's level is the unsigned field `reqLevel[i*LVL_W +: LVL_W]`, and a larger value means a higher priority.
- R3: A requester with `reqDirect[i]` = 1 has effective level 0, whatever its level field holds.
- R4: Ties at the winning level go to the first tied requester at or above the pointer, wrapping from N-1 to 0. When a packet is released, the pointer moves to the owner's index plus one, modulo N.
- R5: `grantVec` is always zero or one-hot. It is idle when no packet is held. When eligible requests are present at a clock edge in the idle state, the grant for the winner appears after that edge.
- R6: While a packet is held, `grantVec` does not change, whatever happens on the request, level and direct-address inputs.
- R7: `endMark` high at an edge while a packet is held clears `grantVec` after that edge. Arbitration resumes at the following edge.
- R8: `errEndMark` releases the output in the same way as `endMark`.
- R9: If `linkDown` of the owner is high at an edge while a packet is held and neither end strobe is high, `forceErrEnd` goes high for exactly one cycle with the grant still held, and the grant is cleared after the next edge. An end strobe in the same cycle takes precedence, and no forced error end is raised.
- R10: A requester whose `linkDown` bit is high is never granted.
- R11: `endMark` and `errEndMark` have no effect while no packet is held. In particular, they do not stop a pending request from being granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | N | Request for this output, one bit per input port |
| reqLevel | input | N*LVL_W | Priority level field per requester, from the routing table |
| reqDirect | input | N | Requester's packet is directly addressed (lowest level) |
| linkDown | input | N | Link of the input port has failed |
| endMark | input | 1 | End marker passed from the granted input |
| errEndMark | input | 1 | Error-end marker passed from the granted input |
| grantVec | output | N | One-hot grant, or zero |
| forceErrEnd | output | 1 | Request to push an error end onto the output |

## Verification
The assertions assume that the end strobes come only from the current owner, so they treat a strobe in the hold state as the end of that owner's packet. They also assume that the inputs settle between clock edges. The stimulus drives every input on the falling edge. It mixes random request vectors, levels, direct flags and sparse link failures with end strobes, some of them deliberately issued while the arbiter is idle. A link failure is raised on the owner only during a held packet, and sometimes in the same cycle as an end strobe, to reach the precedence case.

// File: rtl/oparb_pkg.sv
package oparb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_FLUSH = 2'd2
  } arbState_e;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
    logic advancePtr;
  } arbCtrl_t;

endpackage

// File: rtl/oparb_datapath.sv
module oparb_datapath
  import oparb_pkg::*;
#(
  parameter int N     = 11,
  parameter int LVL_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N-1:0]       reqVec,
  input  logic [N*LVL_W-1:0] reqLevel,
  input  logic [N-1:0]       reqDirect,
  input  logic [N-1:0]       linkDown,
  input  arbCtrl_t           ctrl,
  output logic               anyElig,
  output logic               ownerDown,
  output logic [N-1:0]       grantVec
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [LVL_W-1:0] lvl_t;

  lvl_t         effLevel [N];
  logic [N-1:0] elig;
  logic [N-1:0] topMask;
  lvl_t         maxLvl;
  idx_t         ptr;
  idx_t         ownerIdx;
  idx_t         pickIdx;
  int           scanIdx;

  // effective level and eligibility per requester
  for (genvar gi = 0; gi < N; gi++) begin : g_req
    assign effLevel[gi] = reqDirect[gi] ? lvl_t'(0) : reqLevel[gi*LVL_W +: LVL_W];
    assign elig[gi]     = reqVec[gi] & ~linkDown[gi];
  end

  assign anyElig = |elig;

  // stage 1: highest level present
  always_comb begin
    maxLvl = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (effLevel[i] > maxLvl)) maxLvl = effLevel[i];
    end
  end

  for (genvar gm = 0; gm < N; gm++) begin : g_top
    assign topMask[gm] = elig[gm] && (effLevel[gm] == maxLvl);
  end

  // stage 2: rotating scan from the pointer
  always_comb begin
    logic found;
    found   = 1'b0;
    pickIdx = '0;
    scanIdx = 0;
    for (int off = 0; off < N; off++) begin
      scanIdx = int'(ptr) + off;
      if (scanIdx >= N) scanIdx = scanIdx - N;
      if (!found && topMask[scanIdx]) begin
        found   = 1'b1;
        pickIdx = idx_t'(scanIdx);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantVec <= '0;
      ownerIdx <= '0;
      ptr      <= '0;
    end else begin
      if (ctrl.loadGrant) begin
        grantVec <= N'(1) << pickIdx;
        ownerIdx <= pickIdx;
      end else if (ctrl.clearGrant) begin
        grantVec <= '0;
      end
      if (ctrl.advancePtr) begin
        ptr <= (int'(ownerIdx) == N - 1) ? idx_t'(0) : ownerIdx + idx_t'(1);
      end
    end
  end

  assign ownerDown = |(grantVec & linkDown);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R5

  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|grantVec) |-> ((grantVec & $past(reqVec)) != '0)); // R5

  AST_NO_DOWN_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|grantVec) |-> ((grantVec & $past(linkDown)) == '0)); // R10

endmodule

// File: rtl/oparb_control.sv
module oparb_control
  import oparb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     anyElig,
  input  logic     ownerDown,
  input  logic     endMark,
  input  logic     errEndMark,
  output arbCtrl_t ctrl,
  output logic     holding,
  output logic     forceErrEnd
);

  arbState_e state;
  arbState_e stateNext;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (anyElig) begin
          ctrl.loadGrant = 1'b1;
          stateNext      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (endMark || errEndMark) begin
          ctrl.clearGrant = 1'b1;
          ctrl.advancePtr = 1'b1;
          stateNext       = ST_IDLE;
        end else if (ownerDown) begin
          stateNext = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        ctrl.clearGrant = 1'b1;
        ctrl.advancePtr = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign holding     = (state == ST_HOLD);
  assign forceErrEnd = (state == ST_FLUSH);

  AST_FLUSH_FROM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forceErrEnd) |-> ($past(holding) && $past(ownerDown))); // R9

  AST_END_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (holding && (endMark || errEndMark)) |=> !forceErrEnd); // R9

endmodule

// File: rtl/out_port_arbiter.sv
module out_port_arbiter
  import oparb_pkg::*;
#(
  parameter int N     = 11,
  parameter int LVL_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N-1:0]       reqVec,
  input  logic [N*LVL_W-1:0] reqLevel,
  input  logic [N-1:0]       reqDirect,
  input  logic [N-1:0]       linkDown,
  input  logic               endMark,
  input  logic               errEndMark,
  output logic [N-1:0]       grantVec,
  output logic               forceErrEnd
);

  arbCtrl_t ctrl;
  logic     anyElig;
  logic     ownerDown;
  logic     holding;

  oparb_datapath #(.N(N), .LVL_W(LVL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .reqLevel  (reqLevel),
    .reqDirect (reqDirect),
    .linkDown  (linkDown),
    .ctrl      (ctrl),
    .anyElig   (anyElig),
    .ownerDown (ownerDown),
    .grantVec  (grantVec)
  );

  oparb_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .anyElig     (anyElig),
    .ownerDown   (ownerDown),
    .endMark     (endMark),
    .errEndMark  (errEndMark),
    .ctrl        (ctrl),
    .holding     (holding),
    .forceErrEnd (forceErrEnd)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (holding && !endMark && !errEndMark) |=> $stable(grantVec)); // R6

  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (holding && (endMark || errEndMark)) |=> (grantVec == '0)); // R7 R8

  AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    forceErrEnd |-> (grantVec != '0)); // R9

  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    forceErrEnd |=> (!forceErrEnd && grantVec == '0)); // R9

endmodule

// File: tb/out_port_arbiter_test.sv
module out_port_arbiter_test;

  localparam int N          = 11;
  localparam int LVL_W      = 2;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rstN;
  logic [N-1:0]       reqVec;
  logic [N*LVL_W-1:0] reqLevel;
  logic [N-1:0]       reqDirect;
  logic [N-1:0]       linkDown;
  logic               endMark;
  logic               errEndMark;
  logic [N-1:0]       grantVec;
  logic               forceErrEnd;

  int compared   = 0;
  int mismatched = 0;
  int mState     = 0;   // 0 idle, 1 hold, 2 flush
  int mOwner     = 0;
  int mPtr       = 0;
  bit finished   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  out_port_arbiter #(.N(N), .LVL_W(LVL_W)) uut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .reqLevel(reqLevel),
    .reqDirect(reqDirect), .linkDown(linkDown), .endMark(endMark),
    .errEndMark(errEndMark), .grantVec(grantVec), .forceErrEnd(forceErrEnd)
  );

  function automatic int effLvl(int i);
    return reqDirect[i] ? 0 : int'(reqLevel[i*LVL_W +: LVL_W]);
  endfunction

  function automatic int modelPick();
    int best = -1;
    int bestLvl = -1;
    for (int off = 0; off < N; off++) begin
      int idx = (mPtr + off) % N;
      if (reqVec[idx] && !linkDown[idx] && effLvl(idx) > bestLvl) begin
        best = idx;
        bestLvl = effLvl(idx);
      end
    end
    return best;
  endfunction

  function automatic logic [N-1:0] expGrant();
    return (mState != 0) ? (N'(1) << mOwner) : '0;
  endfunction

  task automatic check(input logic [N-1:0] eg, input logic ef, input string tag);
    compared++;
    if (grantVec !== eg || forceErrEnd !== ef) begin
      mismatched++;
      $display("FAIL %s: grant=%h fe=%b expected grant=%h fe=%b",
               tag, grantVec, forceErrEnd, eg, ef);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    case (mState)
      0: begin
        int p = modelPick();
        if (p >= 0) begin mOwner = p; mState = 1; end
      end
      1: begin
        if (endMark || errEndMark) begin mState = 0; mPtr = (mOwner + 1) % N; end
        else if (linkDown[mOwner]) mState = 2;
      end
      default: begin mState = 0; mPtr = (mOwner + 1) % N; end
    endcase
    @(negedge clk);
    check(expGrant(), (mState == 2), tag);
  endtask

  task automatic setReq(input int i, input int lvl, input bit dir);
    reqVec[i] = 1'b1;
    reqLevel[i*LVL_W +: LVL_W] = LVL_W'(lvl);
    reqDirect[i] = dir;
  endtask

  task automatic clearAll();
    reqVec = '0; reqLevel = '0; reqDirect = '0; linkDown = '0;
    endMark = 1'b0; errEndMark = 1'b0;
  endtask

  task automatic endPacket(input string tag);
    endMark = 1'b1;
    tick(tag);
    check('0, 1'b0, tag);
    endMark = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    clearAll();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check('0, 1'b0, "R1 reset");
    rstN = 1'b1;

    // R5: single request is granted after one edge
    setReq(3, 1, 0);
    tick("R5 single");
    check(N'(1) << 3, 1'b0, "R5 single grant");
    // R6: higher request arriving mid-packet does not steal
    setReq(8, 3, 0);
    tick("R6 hold");
    check(N'(1) << 3, 1'b0, "R6 hold");
    endPacket("R7 end release");
    // R2: level 3 beats level 1
    tick("R2 level");
    check(N'(1) << 8, 1'b0, "R2 level");
    errEndMark = 1'b1;
    tick("R8 error end");
    check('0, 1'b0, "R8 error end");
    clearAll();

    // R3: direct-addressed level field ignored
    setReq(2, 3, 1);
    setReq(5, 1, 0);
    tick("R3 direct");
    check(N'(1) << 5, 1'b0, "R3 direct");
    endPacket("R7 end");
    clearAll();

    // R4: ties rotate (pointer now 6)
    setReq(0, 2, 0); setReq(4, 2, 0); setReq(9, 2, 0);
    tick("R4 tie a"); check(N'(1) << 9, 1'b0, "R4 tie a");
    endPacket("R4 end a");
    tick("R4 tie b"); check(N'(1) << 0, 1'b0, "R4 tie b");
    endPacket("R4 end b");
    tick("R4 tie c"); check(N'(1) << 4, 1'b0, "R4 tie c");
    endPacket("R4 end c");
    clearAll();
    tick("R5 idle");

    // R11: end strobe in idle does not block a pending grant
    setReq(0, 0, 0); setReq(9, 0, 0);
    endMark = 1'b1;
    tick("R11 idle strobe");
    check(N'(1) << 9, 1'b0, "R11 idle strobe");
    endMark = 1'b0;
    endPacket("R7 end");
    clearAll();

    // R10: failed link never granted; R9: owner link failure
    setReq(1, 3, 0); linkDown[1] = 1'b1;
    setReq(6, 0, 0);
    tick("R10 down excluded");
    check(N'(1) << 6, 1'b0, "R10 down excluded");
    linkDown[6] = 1'b1;
    tick("R9 flush");
    check(N'(1) << 6, 1'b1, "R9 flush");
    tick("R9 release");
    check('0, 1'b0, "R9 release");
    clearAll();

    // R9: end strobe wins over same-cycle link failure
    setReq(2, 1, 0);
    tick("R9 setup");
    linkDown[2] = 1'b1; endMark = 1'b1;
    tick("R9 precedence");
    check('0, 1'b0, "R9 precedence");
    clearAll();
    tick("R1 quiet");

    // random packets
    for (int pkt = 0; pkt < 400; pkt++) begin
      clearAll();
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(2) == 0) setReq(i, int'($urandom_range(3)), ($urandom_range(3) == 0));
        if ($urandom_range(7) == 0) linkDown[i] = 1'b1;
      end
      if ($urandom_range(9) == 0) endMark = 1'b1;
      tick("R2 R3 R4 R10 R11 random grant");
      endMark = 1'b0;
      for (int h = 0; h < int'($urandom_range(4)); h++) begin
        reqVec = N'($urandom); reqDirect = N'($urandom);
        reqLevel = (N*LVL_W)'($urandom);
        tick("R6 random hold");
      end
      case ($urandom_range(3))
        0: endMark = 1'b1;
        1: errEndMark = 1'b1;
        2: if (mState == 1) linkDown[mOwner] = 1'b1;
        default: begin
          endMark = 1'b1;
          if (mState == 1) linkDown[mOwner] = 1'b1;
        end
      endcase
      tick("R7 R8 R9 random end");
      endMark = 1'b0; errEndMark = 1'b0;
      tick("R9 random after");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule